// File: doc/BRIEF.md
# Regulator Control Register Slave on I2C

This block is the serial control port of a five-rail regulator controller. An external I2C master reaches seven byte-wide configuration registers through it: five rail-voltage registers, one reset and power-good control register, and one register that turns rails on and off. The register contents leave the block as parallel buses, and the analog side consumes them directly. SCL and SDA are oversampled on the system clock. The block drives SDA as an open-drain line: it only ever pulls SDA low, through a single enable output.

Every transfer begins by loading a one-byte register pointer. A write carries data bytes after the pointer, and each byte lands in the register that the pointer names. A read needs a second address phase with the read bit set. That second phase can follow a repeated START, or it can follow a STOP and a fresh START, because the pointer survives the STOP. The pointer never advances on its own.

Two pins set the power-on contents. The address-select pin provides the lowest address bit. The voltage-select pin chooses the default code for rail A. The block captures both pins once after reset and again whenever chip enable is low. Chip enable low also returns every register to its default and leaves the bus ignored.

The protocol engine has nine states:

| State | Role | Leaves on SCL fall to |
|---|---|---|
| IDLE | Waits for START | (START only) |
| ADDR | Shifts in the address byte | ADDR_ACK on a match, IDLE otherwise |
| ADDR_ACK | Drives the acknowledge | RDATA when the read bit is set, PTR otherwise |
| PTR | Shifts in the pointer byte | PTR_ACK |
| PTR_ACK | Drives the acknowledge | WDATA |
| WDATA | Shifts in a data byte | WDATA_ACK, issuing the write |
| WDATA_ACK | Drives the acknowledge | WDATA |
| RDATA | Shifts out the addressed byte | RDATA_ACK |
| RDATA_ACK | Samples the master's acknowledge | RDATA (same byte reloaded) on ACK, IDLE on NACK |

A START from any state moves the engine to ADDR. A STOP or chip enable low moves it to IDLE.

Top module: `pmic_i2c_regs`

## Requirements
- R1: After reset, and after chip enable returns high, the registers hold these defaults:
  - Rail A: 0x27 with the voltage-select pin low, 0x3B with it high.
  - Rails B, D and E: 0x3B.
  - Rail C: 0x37.
  - Control register: 0x06.
  - Rail enables: 5'b00111.
- R2: The block acknowledges only an address byte whose upper seven bits equal 0001000 with the lowest of them replaced by the captured address-select level. Bit 0 of the address byte is R/W, with 1 meaning read. For any other address the block never drives SDA and changes no register.
- R3: The block does not acknowledge the general call address 0x00, and such a transfer changes no register.
- R4: START, address+W, pointer, data, STOP writes the data byte into the register at the pointer. The write is visible on the matching output bus. Pointer map:
  - 0..4: rails A..E.
  - 5: control.
  - 6: rail enables, with bit i controlling rail i (A = bit 0).
- R5: Address+W and pointer, then a repeated START and address+R, returns the addressed register MSB first.
- R6: The pointer survives a STOP, including a STOP that ends a transfer to another device. A later read that begins with address+R returns the register at the kept pointer.
- R7: The pointer never advances. A second read byte after a master ACK repeats the same register. A second data byte in one write overwrites the same register.
- R8: A write to a pointer of 7 or above is acknowledged and changes no register. A read from such a pointer returns 0x00.
- R9: Unused bits read back as 0. In a rail register, bits 7:6 are unused, bit 5 is the discharge enable and bits 4:0 are the voltage code. In the enable register, bits 7:5 are unused.
- R10: While chip enable is low, all registers take their defaults and the block does not drive SDA. It acknowledges nothing and accepts no writes.
- R11: The SDA drive changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en_i | input | 1 | Chip enable; low forces defaults and ignores the bus |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | When high, pulls SDA low |
| addr_sel_i | input | 1 | Address-select pin, captured as the lowest address bit |
| vsel_i | input | 1 | Voltage-select pin that picks rail A's default |
| rail_cfg_o | output | 40 | Rail registers, byte i for rail i: {2'b0, discharge, code[4:0]} |
| ctrl_o | output | 8 | Reset and power-good control register |
| rail_en_o | output | 5 | Rail on/off bits, bit i for rail i |

## Verification
The bench builds the block with its default parameters: device identifier 000100 and a two-stage input synchronizer. SCL runs at a quarter period of ten system clocks. That spacing leaves room for the synchronizer delay and the registered SDA drive between an SCL edge and the moment the bench samples. Two things follow from these values. Switching the select pins and pulsing chip enable reaches both address variants and both rail-A defaults. A pointer of 0xFF exercises the out-of-range read at the top of the 8-bit pointer space.

// File: rtl/pmic_i2c_pkg.sv
`timescale 1ns/1ps
package pmic_i2c_pkg;

    localparam int NUM_RAILS = 5;
    localparam int CTRL_IDX  = NUM_RAILS;
    localparam int ONOFF_IDX = NUM_RAILS + 1;
    localparam int NUM_REGS  = NUM_RAILS + 2;

    localparam logic [7:0]           CTRL_DEFAULT  = 8'h06;
    localparam logic [NUM_RAILS-1:0] ONOFF_DEFAULT = 5'b00111;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } slv_state_t;

    // Default {discharge, code} of a rail; the voltage-select pin affects rail 0 only.
    function automatic logic [5:0] rail_default(input int idx, input logic vsel);
        logic [4:0] code;
        if (idx == 0)      code = vsel ? 5'd27 : 5'd7;
        else if (idx == 2) code = 5'd23;
        else               code = 5'd27;
        return {1'b1, code};
    endfunction

endpackage

// File: rtl/i2c_line_sense.sv
`timescale 1ns/1ps
module i2c_line_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] scl_p;
    logic [DEPTH-1:0] sda_p;
    logic             scl_prev;
    logic             sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[DEPTH-2:0], scl_i};
            sda_p <= {sda_p[DEPTH-2:0], sda_i};
        end
    end

    assign scl_lvl  = scl_p[DEPTH-2];
    assign sda_lvl  = sda_p[DEPTH-2];
    assign scl_prev = scl_p[DEPTH-1];
    assign sda_prev = sda_p[DEPTH-1];

    assign scl_rise = scl_lvl & ~scl_prev;
    assign scl_fall = ~scl_lvl & scl_prev;
    assign start_ev = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_ev  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_slave_fsm.sv
`timescale 1ns/1ps
module i2c_slave_fsm
    import pmic_i2c_pkg::*;
#(
    parameter logic [5:0] DEV_ID = 6'b000100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       a0_i,
    input  logic       scl_lvl,
    input  logic       sda_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic [7:0] rd_data_i,
    output logic [7:0] ptr_o,
    output logic       wr_stb_o,
    output logic [7:0] wr_data_o,
    output logic       sda_oe_o
);
    slv_state_t st, st_n;
    logic [7:0] sh, sh_n;
    logic [3:0] cnt, cnt_n;
    logic [7:0] ptr, ptr_n;
    logic       rw, rw_n;
    logic       mnack, mnack_n;
    logic       wr_n;
    logic       oe_n;

    always_comb begin
        st_n    = st;
        sh_n    = sh;
        cnt_n   = cnt;
        ptr_n   = ptr;
        rw_n    = rw;
        mnack_n = mnack;
        wr_n    = 1'b0;
        if (clear_i) begin
            st_n  = ST_IDLE;
            ptr_n = '0;
            cnt_n = '0;
        end else if (start_ev) begin
            st_n  = ST_ADDR;
            cnt_n = '0;
        end else if (stop_ev) begin
            st_n = ST_IDLE;
        end else begin
            if (scl_rise) begin
                unique case (st)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        sh_n  = {sh[6:0], sda_lvl};
                        cnt_n = cnt + 4'd1;
                    end
                    ST_RDATA:     cnt_n   = cnt + 4'd1;
                    ST_RDATA_ACK: mnack_n = sda_lvl;
                    default: ;
                endcase
            end
            if (scl_fall) begin
                unique case (st)
                    ST_ADDR: if (cnt == 4'd8) begin
                        rw_n = sh[0];
                        st_n = (sh[7:1] == {DEV_ID, a0_i}) ? ST_ADDR_ACK : ST_IDLE;
                    end
                    ST_ADDR_ACK: begin
                        cnt_n = '0;
                        if (rw) begin
                            sh_n = rd_data_i;
                            st_n = ST_RDATA;
                        end else begin
                            st_n = ST_PTR;
                        end
                    end
                    ST_PTR: if (cnt == 4'd8) begin
                        ptr_n = sh;
                        st_n  = ST_PTR_ACK;
                    end
                    ST_PTR_ACK, ST_WDATA_ACK: begin
                        cnt_n = '0;
                        st_n  = ST_WDATA;
                    end
                    ST_WDATA: if (cnt == 4'd8) begin
                        wr_n = 1'b1;
                        st_n = ST_WDATA_ACK;
                    end
                    ST_RDATA: begin
                        if (cnt == 4'd8) st_n = ST_RDATA_ACK;
                        else             sh_n = {sh[6:0], 1'b0};
                    end
                    ST_RDATA_ACK: begin
                        if (mnack) begin
                            st_n = ST_IDLE;
                        end else begin
                            cnt_n = '0;
                            sh_n  = rd_data_i;
                            st_n  = ST_RDATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
        oe_n = (st_n == ST_ADDR_ACK) || (st_n == ST_PTR_ACK) || (st_n == ST_WDATA_ACK)
            || ((st_n == ST_RDATA) && !sh_n[7]);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh    <= '0;
            cnt   <= '0;
            ptr   <= '0;
            rw    <= 1'b0;
            mnack <= 1'b1;
        end else begin
            sh    <= sh_n;
            cnt   <= cnt_n;
            ptr   <= ptr_n;
            rw    <= rw_n;
            mnack <= mnack_n;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe_o <= 1'b0;
            wr_stb_o <= 1'b0;
        end else begin
            sda_oe_o <= oe_n;
            wr_stb_o <= wr_n;
        end
    end

    assign ptr_o     = ptr;
    assign wr_data_o = sh;

    AST_OE_CHANGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> (!scl_lvl || $past(clear_i))); // R11
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe_o); // R2
    AST_PTR_ONLY_ON_PTR_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr) |-> ($past(st) == ST_PTR || $past(clear_i))); // R7

endmodule

// File: rtl/pmic_regfile.sv
`timescale 1ns/1ps
module pmic_regfile
    import pmic_i2c_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic                   vsel_i,
    input  logic                   wr_en_i,
    input  logic [7:0]             wr_addr_i,
    input  logic [7:0]             wr_data_i,
    input  logic [7:0]             rd_addr_i,
    output logic [7:0]             rd_data_o,
    output logic [NUM_RAILS*8-1:0] rail_cfg_o,
    output logic [7:0]             ctrl_o,
    output logic [NUM_RAILS-1:0]   rail_en_o
);
    localparam int PAD = 8 - NUM_RAILS;

    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
        logic [5:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                q <= rail_default(i, 1'b0);
            else if (load_i)                           q <= rail_default(i, vsel_i);
            else if (wr_en_i && wr_addr_i == 8'(i))    q <= wr_data_i[5:0];
        end
        assign rail_cfg_o[8*i +: 8] = {2'b00, q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_o    <= CTRL_DEFAULT;
            rail_en_o <= ONOFF_DEFAULT;
        end else if (load_i) begin
            ctrl_o    <= CTRL_DEFAULT;
            rail_en_o <= ONOFF_DEFAULT;
        end else if (wr_en_i) begin
            if (wr_addr_i == 8'(CTRL_IDX))  ctrl_o    <= wr_data_i;
            if (wr_addr_i == 8'(ONOFF_IDX)) rail_en_o <= wr_data_i[NUM_RAILS-1:0];
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_RAILS; i++)
            if (rd_addr_i == 8'(i)) rd_data_o = rail_cfg_o[8*i +: 8];
        if (rd_addr_i == 8'(CTRL_IDX))  rd_data_o = ctrl_o;
        if (rd_addr_i == 8'(ONOFF_IDX)) rd_data_o = {{PAD{1'b0}}, rail_en_o};
    end

    AST_OOR_WRITE_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i >= 8'(NUM_REGS) && !load_i)
        |=> ($stable(rail_cfg_o) && $stable(ctrl_o) && $stable(rail_en_o))); // R8

endmodule

// File: rtl/pmic_i2c_regs.sv
`timescale 1ns/1ps
module pmic_i2c_regs
    import pmic_i2c_pkg::*;
#(
    parameter logic [5:0] DEV_ID      = 6'b000100,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   chip_en_i,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe_o,
    input  logic                   addr_sel_i,
    input  logic                   vsel_i,
    output logic [NUM_RAILS*8-1:0] rail_cfg_o,
    output logic [7:0]             ctrl_o,
    output logic [NUM_RAILS-1:0]   rail_en_o
);
    logic init_pend, load, a0_q;
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic [7:0] ptr, wr_data, rd_data;
    logic       wr_stb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) init_pend <= 1'b1;
        else        init_pend <= 1'b0;
    end

    assign load = init_pend | ~chip_en_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    a0_q <= 1'b0;
        else if (load) a0_q <= addr_sel_i;
    end

    i2c_line_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_slave_fsm #(.DEV_ID(DEV_ID)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (load),
        .a0_i      (a0_q),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .rd_data_i (rd_data),
        .ptr_o     (ptr),
        .wr_stb_o  (wr_stb),
        .wr_data_o (wr_data),
        .sda_oe_o  (sda_oe_o)
    );

    pmic_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .vsel_i     (vsel_i),
        .wr_en_i    (wr_stb),
        .wr_addr_i  (ptr),
        .wr_data_i  (wr_data),
        .rd_addr_i  (ptr),
        .rd_data_o  (rd_data),
        .rail_cfg_o (rail_cfg_o),
        .ctrl_o     (ctrl_o),
        .rail_en_o  (rail_en_o)
    );

    AST_DISABLE_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en_i |=> (ctrl_o == CTRL_DEFAULT && rail_en_o == ONOFF_DEFAULT)); // R10
    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en_i |=> !sda_oe_o); // R10

endmodule

// File: tb/tb_pmic_i2c_regs.sv
`timescale 1ns/1ps
module tb_pmic_i2c_regs;

    localparam int Q = 10;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, chip_en, addr_sel, vsel;
    logic m_scl_low, m_sda_low;
    logic sda_oe;
    logic scl_line, sda_line;
    logic [39:0] rail_cfg;
    logic [7:0]  ctrl;
    logic [4:0]  rail_en;

    int checks = 0;
    int fails  = 0;
    int oe_violations = 0;
    int oe_edges = 0;
    bit done = 0;

    assign scl_line = !m_scl_low;
    assign sda_line = !(m_sda_low || sda_oe);

    pmic_i2c_regs dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_en_i  (chip_en),
        .scl_i      (scl_line),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .addr_sel_i (addr_sel),
        .vsel_i     (vsel),
        .rail_cfg_o (rail_cfg),
        .ctrl_o     (ctrl),
        .rail_en_o  (rail_en)
    );

    // R11 monitor: SDA drive must not move while SCL is high
    logic prev_scl = 1'b1, prev_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_oe !== prev_oe) begin
                oe_edges++;
                if (scl_line && prev_scl) oe_violations++;
            end
        end
        prev_scl = scl_line;
        prev_oe  = sda_oe;
    end

    function automatic logic [7:0] rail(input int i);
        return rail_cfg[8*i +: 8];
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; wq();
        m_scl_low = 1'b0; wq();
        m_sda_low = 1'b1; wq();
        m_scl_low = 1'b1; wq();
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; wq();
        m_scl_low = 1'b0; wq();
        m_sda_low = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = !b[i]; wq();
            m_scl_low = 1'b0;  wq(); wq();
            m_scl_low = 1'b1;
        end
        m_sda_low = 1'b0; wq();
        m_scl_low = 1'b0; wq();
        ack = !sda_line;  wq();
        m_scl_low = 1'b1;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wq();
            m_scl_low = 1'b0; wq();
            b[i] = sda_line;  wq();
            m_scl_low = 1'b1;
        end
        m_sda_low = give_ack; wq();
        m_scl_low = 1'b0; wq(); wq();
        m_scl_low = 1'b1; wq();
        m_sda_low = 1'b0;
    endtask

    function automatic logic [7:0] addr_byte(input logic a0, input logic rd);
        return {6'b000100, a0, rd};
    endfunction

    task automatic do_write(input logic a0, input logic [7:0] ptr, input logic [7:0] data, output logic ok);
        logic a1, a2, a3;
        bus_start();
        send_byte(addr_byte(a0, 1'b0), a1);
        send_byte(ptr, a2);
        send_byte(data, a3);
        bus_stop();
        ok = a1 && a2 && a3;
    endtask

    task automatic do_read(input logic a0, input logic [7:0] ptr, input logic sep,
                           output logic [7:0] d, output logic ok);
        logic a1, a2, a3;
        bus_start();
        send_byte(addr_byte(a0, 1'b0), a1);
        send_byte(ptr, a2);
        if (sep) begin
            bus_stop(); wq();
        end
        bus_start();
        send_byte(addr_byte(a0, 1'b1), a3);
        recv_byte(1'b0, d);
        bus_stop();
        ok = a1 && a2 && a3;
    endtask

    task automatic test_reset_defaults();
        chk("R1", "rail A default vsel=0", rail(0), 8'h27);
        chk("R1", "rail B default", rail(1), 8'h3B);
        chk("R1", "rail C default", rail(2), 8'h37);
        chk("R1", "rail D default", rail(3), 8'h3B);
        chk("R1", "rail E default", rail(4), 8'h3B);
        chk("R1", "ctrl default", ctrl, 8'h06);
        chk("R1", "enable default", rail_en, 5'b00111);
        chk("R1", "sda idle", sda_oe, 1'b0);
    endtask

    task automatic test_addressing();
        logic ok, ack;
        do_write(1'b0, 8'h06, 8'h1A, ok);
        chk("R2", "write to own address acked", ok, 1'b1);
        chk("R4", "enable register written", rail_en, 5'b11010);
        bus_start();
        send_byte(addr_byte(1'b1, 1'b0), ack);
        if (ack) begin
            send_byte(8'h06, ack);
            send_byte(8'h01, ack);
        end
        bus_stop();
        chk("R2", "other address not acked", ack, 1'b0);
        chk("R2", "other address no effect", rail_en, 5'b11010);
        bus_start();
        send_byte(8'h00, ack);
        if (ack) begin
            send_byte(8'h06, ack);
            send_byte(8'h02, ack);
        end
        bus_stop();
        chk("R3", "general call not acked", ack, 1'b0);
        chk("R3", "general call no effect", rail_en, 5'b11010);
    endtask

    task automatic test_write_readback();
        logic ok;
        logic [7:0] d;
        do_write(1'b0, 8'h05, 8'hA5, ok);
        chk("R4", "ctrl write", ctrl, 8'hA5);
        do_read(1'b0, 8'h05, 1'b0, d, ok);
        chk("R5", "ctrl read repeated start", d, 8'hA5);
        chk("R5", "read acks", ok, 1'b1);
        do_write(1'b0, 8'h02, 8'h12, ok);
        chk("R4", "rail C write", rail(2), 8'h12);
        do_read(1'b0, 8'h02, 1'b0, d, ok);
        chk("R5", "rail C read", d, 8'h12);
    endtask

    task automatic test_stop_separated();
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(addr_byte(1'b0, 1'b0), ack);
        send_byte(8'h02, ack);
        bus_stop(); wq();
        bus_start();
        send_byte(8'hA0, ack);
        bus_stop(); wq();
        chk("R6", "foreign device not acked", ack, 1'b0);
        bus_start();
        send_byte(addr_byte(1'b0, 1'b1), ack);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R6", "address+R acked", ack, 1'b1);
        chk("R6", "stop separated read", d, 8'h12);
    endtask

    task automatic test_no_autoinc();
        logic ack;
        logic [7:0] d0, d1;
        bus_start();
        send_byte(addr_byte(1'b0, 1'b0), ack);
        send_byte(8'h05, ack);
        bus_start();
        send_byte(addr_byte(1'b0, 1'b1), ack);
        recv_byte(1'b1, d0);
        recv_byte(1'b0, d1);
        bus_stop();
        chk("R7", "first read byte", d0, 8'hA5);
        chk("R7", "second read byte same reg", d1, 8'hA5);
        bus_start();
        send_byte(addr_byte(1'b0, 1'b0), ack);
        send_byte(8'h03, ack);
        send_byte(8'h11, ack);
        send_byte(8'h2C, ack);
        bus_stop();
        chk("R7", "rail D holds last byte", rail(3), 8'h2C);
        chk("R7", "rail E untouched", rail(4), 8'h3B);
    endtask

    task automatic test_out_of_range();
        logic ok;
        logic [7:0] d;
        logic [39:0] snap_r = rail_cfg;
        logic [7:0]  snap_c = ctrl;
        logic [4:0]  snap_e = rail_en;
        do_write(1'b0, 8'h07, 8'hFF, ok);
        chk("R8", "oor write acked", ok, 1'b1);
        chk("R8", "rails unchanged", rail_cfg == snap_r, 1'b1);
        chk("R8", "ctrl unchanged", ctrl, snap_c);
        chk("R8", "enables unchanged", rail_en, snap_e);
        do_read(1'b0, 8'h07, 1'b0, d, ok);
        chk("R8", "read ptr 7", d, 8'h00);
        do_read(1'b0, 8'hFF, 1'b1, d, ok);
        chk("R8", "read ptr 0xFF", d, 8'h00);
    endtask

    task automatic test_unused_bits();
        logic ok;
        logic [7:0] d;
        do_write(1'b0, 8'h01, 8'hFF, ok);
        chk("R9", "rail B masked", rail(1), 8'h3F);
        do_read(1'b0, 8'h01, 1'b0, d, ok);
        chk("R9", "rail B readback", d, 8'h3F);
        do_write(1'b0, 8'h06, 8'hFF, ok);
        chk("R9", "enables all on", rail_en, 5'b11111);
        do_read(1'b0, 8'h06, 1'b0, d, ok);
        chk("R9", "enable readback", d, 8'h1F);
    endtask

    task automatic test_disable();
        logic ok;
        logic [7:0] d;
        vsel = 1'b1;
        addr_sel = 1'b1;
        chip_en = 1'b0;
        wq();
        do_write(1'b1, 8'h05, 8'h55, ok);
        chk("R10", "no ack while disabled", ok, 1'b0);
        chk("R10", "ctrl default while disabled", ctrl, 8'h06);
        chk("R10", "enables default while disabled", rail_en, 5'b00111);
        chk("R10", "rail B default while disabled", rail(1), 8'h3B);
        chip_en = 1'b1;
        wq();
        chk("R1", "rail A default vsel=1", rail(0), 8'h3B);
        chk("R1", "rail D default after enable", rail(3), 8'h3B);
        do_read(1'b1, 8'h00, 1'b0, d, ok);
        chk("R2", "A0=1 address acked", ok, 1'b1);
        chk("R2", "read rail A via A0=1", d, 8'h3B);
        do_write(1'b0, 8'h05, 8'h99, ok);
        chk("R2", "old address ignored", ctrl, 8'h06);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        chip_en = 1'b1;
        addr_sel = 1'b0;
        vsel = 1'b0;
        m_scl_low = 1'b0;
        m_sda_low = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wq();
        test_reset_defaults();
        test_addressing();
        test_write_readback();
        test_stop_separated();
        test_no_autoinc();
        test_out_of_range();
        test_unused_bits();
        test_disable();
        chk("R11", "sda drive moved with SCL high", oe_violations, 0);
        chk("R11", "sda drive exercised", oe_edges > 0, 1'b1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule